// File: doc/BRIEF.md
# SIMD Conversion Fault Checker

This block decides whether a packed conversion instruction in a SIMD execution pipeline may retire or must trap. It looks at a snapshot of the processor state for that instruction: control enables, CPU feature availability, the lock prefix, pending floating-point conditions, the operand address and segment, the privilege level, the operating mode, and whether the source is a register or memory. When at least one fault condition holds, it reports exactly one fault vector and an error code, if that fault carries one. Address translation is not part of the block. A page fault found elsewhere is passed in and takes its place in the priority order.

Three instruction forms are supported: packed integer to double, packed integer to single, and packed single to integer (128-bit source). Memory operands are 8 bytes for the first two forms and 16 bytes for the third. A request presented with `req_valid` is evaluated combinationally. The result is registered, so it appears on the outputs one clock later. When no condition holds, `flt_valid` stays low.

Top module: `simd_fault_check`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset with no request, `flt_valid` is 0.
- R2: The outputs describe the request presented in the previous cycle. `flt_valid` is 1 exactly when that request had `req_valid`=1 and at least one fault condition; otherwise it is 0.
- R3: Decode faults give vector 6 with no error code. A decode fault is raised when `ctl_em`=1, `ctl_fxsr_on`=0, `lock_pfx`=1, `op_form`=3 (reserved), or the feature bit the form needs is 0. Form 1 (`op_form`=1, integer to single) needs `has_sp_simd`. Forms 0 (integer to double) and 2 (single to integer) need `has_dp_simd`.
- R4: `ctl_ts`=1 gives vector 7 with no error code.
- R5: `x87_pending`=1 gives vector 16 with no error code for form 1 (any operand) and for form 0 with a register operand. It is ignored for form 0 with a memory operand and for form 2.
- R6: With a memory operand in form 2, an address whose low 4 bits are not zero gives vector 13. In `mode` 2 (protected) and 3 (64-bit) this carries error code 0.
- R7: In `mode` 0 (real) and 1 (virtual-8086), a memory operand with any byte above offset 0xFFFF gives vector 13 with no error code. This means addr + size > 0x10000. Any vector-13 fault in these modes carries no error code.
- R8: In `mode` 3, a memory address whose bits 63:47 are not all equal gives vector 12 when `seg_is_stack`=1 and vector 13 otherwise, each with error code 0.
- R9: `pf_in`=1 with a memory operand gives vector 14 with error code `pf_code`. With a register operand, `pf_in` is ignored.
- R10: Vector 17 with error code 0 is raised when all of these hold: a memory operand, `align_chk_en`=1, an address that is not a multiple of the operand size, a `mode` other than 0, and either `cpl`=3 or `mode`=1.
- R11: `simd_unmasked`=1 for forms 1 and 2 gives vector 19 when `ctl_xmmexc_on`=1 and vector 6 otherwise, both with no error code. For form 0 it is ignored.
- R12: When several conditions hold, only the first in this order is reported: decode (R3), R4, R5, address (R6 to R8, with R6 ahead of R7 and R8), R9, R10, R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| op_form | input | 2 | 0 int-to-double, 1 int-to-single, 2 single-to-int, 3 reserved |
| src_is_mem | input | 1 | Source operand is in memory |
| mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compat, 3 64-bit |
| ctl_ts | input | 1 | Task-switched flag (control register 0 bit 3) |
| ctl_em | input | 1 | Emulation flag (control register 0 bit 2) |
| ctl_fxsr_on | input | 1 | OS SIMD state save support (control register 4 bit 9) |
| ctl_xmmexc_on | input | 1 | OS SIMD FP trap support (control register 4 bit 10) |
| has_sp_simd | input | 1 | Single-precision SIMD feature (feature word bit 25) |
| has_dp_simd | input | 1 | Double-precision SIMD feature (feature word bit 26) |
| lock_pfx | input | 1 | Lock prefix present |
| x87_pending | input | 1 | Pending x87 floating-point error |
| simd_unmasked | input | 1 | Unmasked SIMD FP exception produced |
| addr | input | ADDR_W | Operand linear/effective address |
| seg_is_stack | input | 1 | Reference uses the stack segment |
| align_chk_en | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| pf_in | input | 1 | Page fault detected by translation |
| pf_code | input | ERR_W | Page-fault error code |
| flt_valid | output | 1 | Fault reported for previous request |
| flt_vec | output | 8 | Fault vector number |
| flt_has_err | output | 1 | Fault pushes an error code |
| flt_err | output | ERR_W | Error code value |

## Verification
The checker itself holds no state beyond one result register. A wrong internal state therefore shows up on the outputs in the cycle that follows the request, either as the wrong vector or as a missing or extra `flt_valid`. The most likely internal faults are a priority slot wired out of order, a misread enable polarity, or a wrong size or limit in the address arithmetic. Each shows as a different vector, or a different error-code flag, on a request that combines two conditions. For that reason, the sweep crosses every form, mode, operand kind and address class with many mixtures of the flag inputs, and checks each result one cycle after its request.

// File: rtl/simd_flt_pkg.sv
package simd_flt_pkg;

  localparam int ADDR_W_DEF = 64;
  localparam int ERR_W_DEF  = 32;
  localparam int NSLOT      = 7;

  typedef enum logic [1:0] {
    FORM_I2D = 2'd0,
    FORM_I2S = 2'd1,
    FORM_S2I = 2'd2,
    FORM_RSV = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    MD_REAL = 2'd0,
    MD_V86  = 2'd1,
    MD_PROT = 2'd2,
    MD_LONG = 2'd3
  } mode_e;

  // priority slots, lowest index wins
  localparam int SL_DEC  = 0;
  localparam int SL_DNA  = 1;
  localparam int SL_X87  = 2;
  localparam int SL_ADR  = 3;
  localparam int SL_PAGE = 4;
  localparam int SL_ALN  = 5;
  localparam int SL_SIMD = 6;

  localparam logic [7:0] VEC_UD = 8'd6;
  localparam logic [7:0] VEC_NM = 8'd7;
  localparam logic [7:0] VEC_SS = 8'd12;
  localparam logic [7:0] VEC_GP = 8'd13;
  localparam logic [7:0] VEC_PF = 8'd14;
  localparam logic [7:0] VEC_MF = 8'd16;
  localparam logic [7:0] VEC_AC = 8'd17;
  localparam logic [7:0] VEC_XM = 8'd19;

  // bytes touched by the memory form of each conversion
  function automatic int unsigned op_bytes(input logic [1:0] form);
    return (form == FORM_S2I) ? 16 : 8;
  endfunction

  // true when addr is not a multiple of nbytes (power of two)
  function automatic logic is_misaligned(input logic [ADDR_W_DEF-1:0] a,
                                         input int unsigned nbytes);
    logic [ADDR_W_DEF-1:0] mask;
    mask = ADDR_W_DEF'(nbytes) - 1'b1;
    return (a & mask) != '0;
  endfunction

  // top bits from va_bits-1 upward must be all zero or all one
  function automatic logic is_canonical(input logic [ADDR_W_DEF-1:0] a,
                                        input int unsigned va_bits);
    logic [ADDR_W_DEF-1:0] top;
    logic [ADDR_W_DEF-1:0] ones;
    top  = a >> (va_bits - 1);
    ones = {ADDR_W_DEF{1'b1}} >> (va_bits - 1);
    return (top == '0) || (top == ones);
  endfunction

  // true when the last byte of an access lies beyond the segment limit
  function automatic logic overruns_limit(input logic [ADDR_W_DEF-1:0] a,
                                          input int unsigned nbytes,
                                          input logic [ADDR_W_DEF-1:0] limit);
    logic [ADDR_W_DEF:0] end_x;
    logic [ADDR_W_DEF:0] lim_x;
    end_x = {1'b0, a} + (ADDR_W_DEF+1)'(nbytes);
    lim_x = {1'b0, limit} + 1'b1;
    return end_x > lim_x;
  endfunction

endpackage

// File: rtl/sfc_state_gate.sv
module sfc_state_gate
  import simd_flt_pkg::*;
(
  input  logic [1:0] op_form,
  input  logic       src_is_mem,
  input  logic       ctl_ts,
  input  logic       ctl_em,
  input  logic       ctl_fxsr_on,
  input  logic       ctl_xmmexc_on,
  input  logic       has_sp_simd,
  input  logic       has_dp_simd,
  input  logic       lock_pfx,
  input  logic       x87_pending,
  input  logic       simd_unmasked,
  output logic       dec_hit,
  output logic       dna_hit,
  output logic       x87_hit,
  output logic       simd_hit,
  output logic       simd_trap
);

  logic feat_ok;
  logic x87_applies;
  logic simd_applies;

  always_comb begin
    unique case (op_form)
      FORM_I2S: feat_ok = has_sp_simd;
      FORM_I2D,
      FORM_S2I: feat_ok = has_dp_simd;
      default:  feat_ok = 1'b0;
    endcase
  end

  assign dec_hit = ctl_em | ~ctl_fxsr_on | lock_pfx | ~feat_ok;
  assign dna_hit = ctl_ts;

  // register forms touch MMX state; the int-to-single memory form does too
  assign x87_applies  = (op_form == FORM_I2S) ||
                        ((op_form == FORM_I2D) && !src_is_mem);
  assign x87_hit      = x87_pending & x87_applies;

  assign simd_applies = (op_form == FORM_I2S) || (op_form == FORM_S2I);
  assign simd_hit     = simd_unmasked & simd_applies;
  assign simd_trap    = ctl_xmmexc_on;

endmodule

// File: rtl/sfc_addr_check.sv
module sfc_addr_check
  import simd_flt_pkg::*;
#(
  parameter int ADDR_W     = ADDR_W_DEF,
  parameter int VA_BITS    = 48,
  parameter int ALIGN_WIDE = 16,
  parameter logic [ADDR_W-1:0] REAL_LIMIT = ADDR_W'(16'hFFFF)
) (
  input  logic [1:0]        op_form,
  input  logic [1:0]        mode,
  input  logic              src_is_mem,
  input  logic [ADDR_W-1:0] addr,
  input  logic              seg_is_stack,
  input  logic              align_chk_en,
  input  logic [1:0]        cpl,
  output logic              adr_hit,
  output logic              adr_use_ss,
  output logic              adr_has_err,
  output logic              aln_hit
);

  localparam int unsigned WIDE_B = ALIGN_WIDE;

  logic              legacy_md;
  logic              wide_bad;
  logic              limit_bad;
  logic              canon_bad;
  int unsigned       nbytes;

  assign nbytes    = op_bytes(op_form);
  assign legacy_md = (mode == MD_REAL) || (mode == MD_V86);

  assign wide_bad  = src_is_mem && (op_form == FORM_S2I) &&
                     is_misaligned(addr, WIDE_B);
  assign limit_bad = src_is_mem && legacy_md &&
                     overruns_limit(addr, nbytes, REAL_LIMIT);
  assign canon_bad = src_is_mem && (mode == MD_LONG) &&
                     !is_canonical(addr, VA_BITS);

  assign adr_hit     = wide_bad | limit_bad | canon_bad;
  // stack segment only matters for the canonical test, after alignment
  assign adr_use_ss  = !wide_bad && canon_bad && seg_is_stack;
  assign adr_has_err = !legacy_md;

  assign aln_hit = src_is_mem && align_chk_en && (mode != MD_REAL) &&
                   ((cpl == 2'd3) || (mode == MD_V86)) &&
                   is_misaligned(addr, nbytes);

endmodule

// File: rtl/sfc_prio_pick.sv
module sfc_prio_pick #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win,
  output logic         any
);

  logic [N:0] lower_any;

  assign lower_any[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign win[g]         = req[g] & ~lower_any[g];
    assign lower_any[g+1] = lower_any[g] | req[g];
  end

  assign any = lower_any[N];

endmodule

// File: rtl/simd_fault_check.sv
module simd_fault_check
  import simd_flt_pkg::*;
#(
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter int ERR_W   = ERR_W_DEF,
  parameter int VA_BITS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        op_form,
  input  logic              src_is_mem,
  input  logic [1:0]        mode,
  input  logic              ctl_ts,
  input  logic              ctl_em,
  input  logic              ctl_fxsr_on,
  input  logic              ctl_xmmexc_on,
  input  logic              has_sp_simd,
  input  logic              has_dp_simd,
  input  logic              lock_pfx,
  input  logic              x87_pending,
  input  logic              simd_unmasked,
  input  logic [ADDR_W-1:0] addr,
  input  logic              seg_is_stack,
  input  logic              align_chk_en,
  input  logic [1:0]        cpl,
  input  logic              pf_in,
  input  logic [ERR_W-1:0]  pf_code,
  output logic              flt_valid,
  output logic [7:0]        flt_vec,
  output logic              flt_has_err,
  output logic [ERR_W-1:0]  flt_err
);

  logic dec_hit, dna_hit, x87_hit, simd_hit, simd_trap;
  logic adr_hit, adr_use_ss, adr_has_err, aln_hit;
  logic [NSLOT-1:0] cause_vec;
  logic [NSLOT-1:0] win_onehot;
  logic             any_cause;
  logic [7:0]       nxt_vec;
  logic             nxt_has_err;
  logic [ERR_W-1:0] nxt_err;

  sfc_state_gate u_gate (
    .op_form      (op_form),
    .src_is_mem   (src_is_mem),
    .ctl_ts       (ctl_ts),
    .ctl_em       (ctl_em),
    .ctl_fxsr_on  (ctl_fxsr_on),
    .ctl_xmmexc_on(ctl_xmmexc_on),
    .has_sp_simd  (has_sp_simd),
    .has_dp_simd  (has_dp_simd),
    .lock_pfx     (lock_pfx),
    .x87_pending  (x87_pending),
    .simd_unmasked(simd_unmasked),
    .dec_hit      (dec_hit),
    .dna_hit      (dna_hit),
    .x87_hit      (x87_hit),
    .simd_hit     (simd_hit),
    .simd_trap    (simd_trap)
  );

  sfc_addr_check #(
    .ADDR_W (ADDR_W),
    .VA_BITS(VA_BITS)
  ) u_addr (
    .op_form     (op_form),
    .mode        (mode),
    .src_is_mem  (src_is_mem),
    .addr        (addr),
    .seg_is_stack(seg_is_stack),
    .align_chk_en(align_chk_en),
    .cpl         (cpl),
    .adr_hit     (adr_hit),
    .adr_use_ss  (adr_use_ss),
    .adr_has_err (adr_has_err),
    .aln_hit     (aln_hit)
  );

  always_comb begin
    cause_vec          = '0;
    cause_vec[SL_DEC]  = dec_hit;
    cause_vec[SL_DNA]  = dna_hit;
    cause_vec[SL_X87]  = x87_hit;
    cause_vec[SL_ADR]  = adr_hit;
    cause_vec[SL_PAGE] = pf_in & src_is_mem;
    cause_vec[SL_ALN]  = aln_hit;
    cause_vec[SL_SIMD] = simd_hit;
  end

  sfc_prio_pick #(.N(NSLOT)) u_pick (
    .req(cause_vec),
    .win(win_onehot),
    .any(any_cause)
  );

  always_comb begin
    nxt_vec     = '0;
    nxt_has_err = 1'b0;
    nxt_err     = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (win_onehot[s]) begin
        unique case (s)
          SL_DEC:  nxt_vec = VEC_UD;
          SL_DNA:  nxt_vec = VEC_NM;
          SL_X87:  nxt_vec = VEC_MF;
          SL_ADR: begin
            nxt_vec     = adr_use_ss ? VEC_SS : VEC_GP;
            nxt_has_err = adr_has_err;
          end
          SL_PAGE: begin
            nxt_vec     = VEC_PF;
            nxt_has_err = 1'b1;
            nxt_err     = pf_code;
          end
          SL_ALN: begin
            nxt_vec     = VEC_AC;
            nxt_has_err = 1'b1;
          end
          default: nxt_vec = simd_trap ? VEC_XM : VEC_UD;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_valid   <= 1'b0;
      flt_vec     <= '0;
      flt_has_err <= 1'b0;
      flt_err     <= '0;
    end else begin
      flt_valid   <= req_valid & any_cause;
      flt_vec     <= req_valid ? nxt_vec     : '0;
      flt_has_err <= req_valid ? nxt_has_err : 1'b0;
      flt_err     <= req_valid ? nxt_err     : '0;
    end
  end

endmodule

// File: rtl/simd_fault_chk.sv
module simd_fault_chk #(
  parameter int N     = 7,
  parameter int ERR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [N-1:0]     cause_vec,
  input logic [N-1:0]     win_onehot,
  input logic             flt_valid,
  input logic [7:0]       flt_vec,
  input logic             flt_has_err,
  input logic [ERR_W-1:0] flt_err
);

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot)); // R12

  AST_WINNER_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (|cause_vec) == (|win_onehot)); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !flt_valid); // R2

  AST_CAUSE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && |cause_vec) |=> flt_valid); // R2

  AST_DECODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cause_vec[0]) |=> (flt_vec == 8'd6 && !flt_has_err)); // R3

  AST_DNA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cause_vec[0] && cause_vec[1]) |=> (flt_vec == 8'd7)); // R4

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_has_err && flt_vec != 8'd14) |-> (flt_err == '0)); // R6

endmodule

bind simd_fault_check simd_fault_chk #(.N(7), .ERR_W(ERR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .cause_vec  (cause_vec),
  .win_onehot (win_onehot),
  .flt_valid  (flt_valid),
  .flt_vec    (flt_vec),
  .flt_has_err(flt_has_err),
  .flt_err    (flt_err)
);

// File: tb/simd_fault_check_bench.sv
module simd_fault_check_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  op_form = '0;
  logic        src_is_mem = 1'b0;
  logic [1:0]  mode = '0;
  logic        ctl_ts = 1'b0, ctl_em = 1'b0, ctl_fxsr_on = 1'b1, ctl_xmmexc_on = 1'b0;
  logic        has_sp_simd = 1'b1, has_dp_simd = 1'b1;
  logic        lock_pfx = 1'b0, x87_pending = 1'b0, simd_unmasked = 1'b0;
  logic [63:0] addr = '0;
  logic        seg_is_stack = 1'b0, align_chk_en = 1'b0;
  logic [1:0]  cpl = '0;
  logic        pf_in = 1'b0;
  logic [31:0] pf_code = '0;
  logic        flt_valid, flt_has_err;
  logic [7:0]  flt_vec;
  logic [31:0] flt_err;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_fault_check u_simd_fault_check (.*);

  typedef struct packed {
    logic        v;
    logic [7:0]  vec;
    logic        he;
    logic [31:0] err;
  } exp_t;

  function automatic string tag_of(input logic [7:0] v, input logic dec);
    case (v)
      8'd6:  return dec ? "R3" : "R11";
      8'd7:  return "R4";
      8'd16: return "R5";
      8'd13: return "R6/R7";
      8'd12: return "R8";
      8'd14: return "R9";
      8'd17: return "R10";
      8'd19: return "R11";
      default: return "R2";
    endcase
  endfunction

  // independent model written as an ordered decision list
  function automatic exp_t model(output logic dec);
    exp_t e;
    int unsigned sz;
    logic legacy, feat;
    logic [63:0] hi;
    e = '0; dec = 1'b0;
    sz = (op_form == 2'd2) ? 16 : 8;
    legacy = (mode < 2'd2);
    feat = (op_form == 2'd1) ? has_sp_simd : has_dp_simd;
    hi = addr >> 47;
    if (ctl_em || !ctl_fxsr_on || lock_pfx || op_form == 2'd3 || !feat) begin
      e.v = 1; e.vec = 8'd6; dec = 1'b1;
    end else if (ctl_ts) begin
      e.v = 1; e.vec = 8'd7;
    end else if (x87_pending && (op_form == 2'd1 || (op_form == 2'd0 && !src_is_mem))) begin
      e.v = 1; e.vec = 8'd16;
    end else if (src_is_mem && op_form == 2'd2 && (addr % 16) != 0) begin
      e.v = 1; e.vec = 8'd13; e.he = !legacy;
    end else if (src_is_mem && legacy && (addr > 64'h1_0000 - sz)) begin
      e.v = 1; e.vec = 8'd13; e.he = 0;
    end else if (src_is_mem && mode == 2'd3 && hi != 0 && hi != 64'h1_FFFF) begin
      e.v = 1; e.vec = seg_is_stack ? 8'd12 : 8'd13; e.he = 1;
    end else if (src_is_mem && pf_in) begin
      e.v = 1; e.vec = 8'd14; e.he = 1; e.err = pf_code;
    end else if (src_is_mem && align_chk_en && mode != 2'd0 &&
                 (cpl == 2'd3 || mode == 2'd1) && (addr % sz) != 0) begin
      e.v = 1; e.vec = 8'd17; e.he = 1;
    end else if (simd_unmasked && op_form != 2'd0) begin
      e.v = 1; e.vec = ctl_xmmexc_on ? 8'd19 : 8'd6;
    end
    return e;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    n_checks++;
    if (flt_valid !== e.v || (e.v && (flt_vec !== e.vec || flt_has_err !== e.he ||
        flt_err !== e.err))) begin
      n_errors++;
      $display("FAIL %s: got v=%0b vec=%0d he=%0b err=%h exp v=%0b vec=%0d he=%0b err=%h form=%0d mode=%0d mem=%0b addr=%h",
               tag, flt_valid, flt_vec, flt_has_err, flt_err, e.v, e.vec, e.he, e.err,
               op_form, mode, src_is_mem, addr);
    end
  endtask

  // inputs are already set at a falling edge; register at rise, sample at next fall
  task automatic issue(input string forced_tag);
    exp_t e;
    logic d;
    e = model(d);
    req_valid = 1'b1;
    @(negedge clk);
    compare(e, (forced_tag != "") ? forced_tag : tag_of(e.vec, d));
  endtask

  task automatic clear_flags();
    ctl_ts = 0; ctl_em = 0; ctl_fxsr_on = 1; ctl_xmmexc_on = 0;
    has_sp_simd = 1; has_dp_simd = 1; lock_pfx = 0; x87_pending = 0;
    simd_unmasked = 0; seg_is_stack = 0; align_chk_en = 0; cpl = 0;
    pf_in = 0; pf_code = '0;
  endtask

  function automatic logic [63:0] addr_class(input int c);
    case (c)
      0: return 64'h0000_0000_0000_1000;
      1: return 64'h0000_0000_0000_1008;
      2: return 64'h0000_0000_0000_1003;
      3: return 64'h0000_0000_0000_FFF8;
      4: return 64'h0000_0000_0000_FFFC;
      5: return 64'h0000_0000_0001_0000;
      6: return 64'h0000_8000_0000_0000;
      default: return 64'hFFFF_8000_0000_0010;
    endcase
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: got hang exp completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : stim
    exp_t quiet;
    logic [31:0] r;
    quiet = '0;
    r = 32'h1234_5678;
    repeat (3) @(negedge clk);
    compare(quiet, "R1");                 // during reset
    rst_n = 1'b1;
    @(negedge clk);
    compare(quiet, "R1");                 // first cycle after reset
    // R2: a faulting state without req_valid stays silent
    ctl_ts = 1;
    req_valid = 0;
    @(negedge clk);
    compare(quiet, "R2");
    clear_flags();

    // directed corner cases
    op_form = 2'd2; src_is_mem = 1; mode = 2'd2; addr = 64'h1008;
    issue("R6");                          // 16-byte alignment, error code 0
    mode = 2'd0; addr = 64'hFFF8;
    issue("R7");                          // 16 bytes from FFF8 overruns
    op_form = 2'd0; addr = 64'hFFF8;
    issue("R7");                          // 8 bytes end at FFFF: no fault
    mode = 2'd3; addr = 64'h0000_8000_0000_0000; seg_is_stack = 1;
    issue("R8");
    addr = 64'h1000; pf_in = 1; pf_code = 32'h0000_0007; src_is_mem = 0;
    issue("R9");                          // register operand ignores page fault
    src_is_mem = 1;
    issue("R9");
    clear_flags(); x87_pending = 1;
    issue("R5");                          // int-to-double memory form: ignored
    simd_unmasked = 1;
    issue("R11");                         // int-to-double ignores SIMD too
    op_form = 2'd1; ctl_ts = 1; lock_pfx = 1;
    issue("R12");                         // decode beats everything
    clear_flags();

    // sweep: every form, mode, operand kind, address class with flag mixes
    for (int f = 0; f < 4; f++)
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 2; k++)
          for (int c = 0; c < 8; c++)
            for (int j = 0; j < 60; j++) begin
              r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
              op_form = 2'(f); mode = 2'(m); src_is_mem = k[0];
              addr = addr_class(c);
              ctl_em        = r[0] & r[1] & r[2];
              ctl_fxsr_on   = r[3] | r[4] | r[5];
              has_sp_simd   = r[6] | r[7] | r[8];
              has_dp_simd   = r[9] | r[10] | r[11];
              lock_pfx      = r[12] & r[13] & r[14];
              ctl_ts        = r[15] & r[16];
              x87_pending   = r[17] & r[18];
              pf_in         = r[19] & r[20];
              pf_code       = {r[31:24], 24'h0} | 32'h1;
              align_chk_en  = r[21];
              cpl           = r[23:22];
              seg_is_stack  = r[24];
              simd_unmasked = r[25] & r[26];
              ctl_xmmexc_on = r[27];
              issue("");
            end

    req_valid = 0;
    @(negedge clk);
    compare(quiet, "R2");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule